// File: doc/BRIEF.md
# Real-Time Clock Host Register Port

This block is the host-side register window of a real-time clock. The host reaches every register through two strobes that share one write-data bus. A pulse on the address strobe loads a register index. A pulse on the data strobe then writes the register that index selects. The selected register is always visible on the read-data output, so a read needs only the address step.

The index space is laid out in three parts. The lowest indices hold the clock and alarm fields. These bytes are not stored here: they live in the timekeeping core. Reads of these indices return the core's bus, and writes to them go out to the core as a one-cycle strobe with the field number and the data.

Four control and status registers follow the clock fields. One holds the rate and divider bits together with a live update-in-progress indicator. One holds the mode bits and the freeze bit, which halts clock updates while the time is being set. One shows the core's interrupt flags. One shows the valid-RAM-and-time flag. The remaining indices form a small user RAM, which the host can read and write freely.

Top module: `rtc_host_regs`

## Requirements
- R1: An address strobe loads bits 5:0 of the write data into the index register. Bits 7:6 are dropped, so an index of 64 or more wraps modulo 64; for example 0x43 selects 3 and 0x7F selects 63. After reset the index is 0.
- R2: For indices 0 to 9, the read data is byte k of the clock bus, where byte k sits at bits 8k+7 down to 8k.
- R3: Index 10 is control register A. Bits 6:0 are host-writable, reset to 0, and are driven on `ctrl_a`. Bit 7 reads as `upd_busy` while the freeze bit is clear and as 0 while it is set. Host writes to bit 7 are ignored.
- R4: Index 11 is control register B. All 8 bits are host-writable and reset to 0. Bit 7 drives `freeze` and bits 6:0 drive `ctrl_b`.
- R5: Index 12 is register C. It reads as `{irq_flags, 4'b0000}`, and host writes to it are ignored.
- R6: Index 13 is register D. It reads as 0x80: the valid flag is 1 after reset and bits 6:0 are zero. Host writes to it are ignored.
- R7: Indices 14 to 63 are a 50-byte user RAM. A read returns the last byte written to that index. When the parameter `RAM_CLEAR` is 1, reset clears the RAM to 0.
- R8: `tod_wr_en` is high only during a data strobe whose current index is 0 to 9. In that cycle `tod_wr_idx` carries the index and `tod_wr_data` carries the write data.
- R9: When the address strobe and the data strobe arrive in the same cycle, the data write uses the index held before that edge. The new index takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adr_we | input | 1 | Address strobe: load the index from `wdata` |
| dat_we | input | 1 | Data strobe: write `wdata` to the selected register |
| wdata | input | 8 | Shared write-data bus |
| rdata | output | 8 | Contents of the selected register |
| tod_rd_bus | input | 80 | Clock and alarm bytes from the timekeeping core |
| upd_busy | input | 1 | Update in progress, from the core |
| irq_flags | input | 4 | Interrupt flags from the core, shown in register C bits 7:4 |
| tod_wr_en | output | 1 | Write strobe for a clock field |
| tod_wr_idx | output | 4 | Clock field number for the write |
| tod_wr_data | output | 8 | Data for the clock field write |
| freeze | output | 1 | Stops clock updates while high |
| ctrl_a | output | 7 | Rate and divider bits of register A |
| ctrl_b | output | 7 | Mode bits of register B |

## Verification
The bench builds the block with the default widths and counts, but overrides `RAM_CLEAR` to 1. With that override, the reset contents of the user RAM are defined and can be checked before any write. The default 6-bit index ends exactly at the last RAM byte. As a result, both the wrap of large index values and the top RAM location at 63 can be reached through the address port. Holding `upd_busy` high while the freeze bit is toggled shows that the update indicator is masked in register A.

// File: rtl/rtc_hreg_pkg.sv
package rtc_hreg_pkg;

   // Selector for the four control/status registers, in index order.
   typedef enum logic [1:0] {
      CR_A = 2'd0,
      CR_B = 2'd1,
      CR_C = 2'd2,
      CR_D = 2'd3
   } ctrl_sel_e;

   // Which part of the index space an index falls in.
   typedef enum logic [1:0] {
      RG_TOD  = 2'd0,
      RG_CTRL = 2'd1,
      RG_RAM  = 2'd2,
      RG_NONE = 2'd3
   } region_e;

   localparam int CTRL_N = 4;

endpackage

// File: rtl/rtc_idx_reg.sv
module rtc_idx_reg #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] idx_in,
   output logic [IDX_W-1:0] idx_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (load)
         idx_q <= idx_in;
   end

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
   import rtc_hreg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  ctrl_sel_e         sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              upd_busy,
   input  logic [DATA_W/2-1:0] irq_flags,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-2:0] a_bits,
   output logic [DATA_W-1:0] b_bits
);

   localparam int FLAG_W = DATA_W / 2;
   localparam int PAD_W  = DATA_W - FLAG_W;

   logic [DATA_W-2:0] a_q;
   logic [DATA_W-1:0] b_q;
   logic              vrt_q;
   logic              frz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= '0;
         b_q   <= '0;
         vrt_q <= 1'b1;
      end else if (wr_en) begin
         case (sel)
            CR_A:    a_q <= wdata[DATA_W-2:0];
            CR_B:    b_q <= wdata;
            default: ;
         endcase
      end
   end

   assign frz = b_q[DATA_W-1];

   always_comb begin
      case (sel)
         CR_A:    rd_data = {upd_busy & ~frz, a_q};
         CR_B:    rd_data = b_q;
         CR_C:    rd_data = {irq_flags, {PAD_W{1'b0}}};
         default: rd_data = {vrt_q, {(DATA_W-1){1'b0}}};
      endcase
   end

   assign a_bits = a_q;
   assign b_bits = b_q;

endmodule

// File: rtl/rtc_user_ram.sv
module rtc_user_ram #(
   parameter int DEPTH     = 50,
   parameter int DATA_W    = 8,
   parameter int AW        = 6,
   parameter bit CLEAR_RST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_RST) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++)
                  mem[i] <= '0;
            end else if (wr_en) begin
               mem[addr] <= wdata;
            end
         end
      end else begin : g_keep
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (wr_en)
               mem[addr] <= wdata;
         end
      end
   endgenerate

   assign rdata = (int'(addr) < DEPTH) ? mem[addr] : '0;

endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
   import rtc_hreg_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int IDX_W     = 6,
   parameter int TOD_N     = 10,
   parameter int RAM_BYTES = 50,
   parameter bit RAM_CLEAR = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adr_we,
   input  logic                    dat_we,
   input  logic [DATA_W-1:0]       wdata,
   output logic [DATA_W-1:0]       rdata,
   input  logic [TOD_N*DATA_W-1:0] tod_rd_bus,
   input  logic                    upd_busy,
   input  logic [DATA_W/2-1:0]     irq_flags,
   output logic                    tod_wr_en,
   output logic [$clog2(TOD_N)-1:0] tod_wr_idx,
   output logic [DATA_W-1:0]       tod_wr_data,
   output logic                    freeze,
   output logic [DATA_W-2:0]       ctrl_a,
   output logic [DATA_W-2:0]       ctrl_b
);

   localparam int TOD_IW   = $clog2(TOD_N);
   localparam int RAM_BASE = TOD_N + CTRL_N;
   localparam int RAM_END  = RAM_BASE + RAM_BYTES;
   localparam int RAM_AW   = $clog2(RAM_BYTES);

   initial begin : chk_params
      assert (RAM_END <= (1 << IDX_W))
         else $fatal(1, "index space too small for registers and RAM");
      assert (IDX_W <= DATA_W && TOD_IW <= IDX_W)
         else $fatal(1, "index width does not fit the data bus");
      assert (DATA_W >= 4 && DATA_W % 2 == 0)
         else $fatal(1, "data width must be even and at least 4");
   end

   logic [IDX_W-1:0]  idx_q;
   int                idx_i;
   region_e           region;
   ctrl_sel_e         csel;
   logic [DATA_W-1:0] ctrl_rd, ram_rd, tod_rd;
   logic [DATA_W-1:0] b_full;
   logic [RAM_AW-1:0] ram_addr;
   logic [DATA_W-1:0] tod_byte [TOD_N];

   rtc_idx_reg #(.IDX_W(IDX_W)) u_idx (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (adr_we),
      .idx_in (wdata[IDX_W-1:0]),
      .idx_q  (idx_q)
   );

   assign idx_i = int'(idx_q);

   always_comb begin
      if (idx_i < TOD_N)         region = RG_TOD;
      else if (idx_i < RAM_BASE) region = RG_CTRL;
      else if (idx_i < RAM_END)  region = RG_RAM;
      else                       region = RG_NONE;
   end

   assign csel     = ctrl_sel_e'(2'(idx_i - TOD_N));
   assign ram_addr = RAM_AW'(idx_i - RAM_BASE);

   rtc_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (dat_we && region == RG_CTRL),
      .sel       (csel),
      .wdata     (wdata),
      .upd_busy  (upd_busy),
      .irq_flags (irq_flags),
      .rd_data   (ctrl_rd),
      .a_bits    (ctrl_a),
      .b_bits    (b_full)
   );

   rtc_user_ram #(
      .DEPTH     (RAM_BYTES),
      .DATA_W    (DATA_W),
      .AW        (RAM_AW),
      .CLEAR_RST (RAM_CLEAR)
   ) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (dat_we && region == RG_RAM),
      .addr  (ram_addr),
      .wdata (wdata),
      .rdata (ram_rd)
   );

   generate
      for (genvar g = 0; g < TOD_N; g++) begin : g_tod
         assign tod_byte[g] = tod_rd_bus[g*DATA_W +: DATA_W];
      end
   endgenerate

   assign tod_rd = (idx_i < TOD_N) ? tod_byte[TOD_IW'(idx_q)] : '0;

   always_comb begin
      case (region)
         RG_TOD:  rdata = tod_rd;
         RG_CTRL: rdata = ctrl_rd;
         RG_RAM:  rdata = ram_rd;
         default: rdata = '0;
      endcase
   end

   assign tod_wr_en   = dat_we && region == RG_TOD;
   assign tod_wr_idx  = TOD_IW'(idx_q);
   assign tod_wr_data = wdata;
   assign freeze      = b_full[DATA_W-1];
   assign ctrl_b      = b_full[DATA_W-2:0];

endmodule

// File: rtl/rtc_host_regs_chk.sv
module rtc_host_regs_chk #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 6,
   parameter int TOD_N  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adr_we,
   input logic              dat_we,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              freeze,
   input logic              tod_wr_en,
   input logic [IDX_W-1:0]  idx_q
);

   localparam logic [IDX_W-1:0] IX_A = IDX_W'(TOD_N);
   localparam logic [IDX_W-1:0] IX_B = IDX_W'(TOD_N + 1);
   localparam logic [IDX_W-1:0] IX_C = IDX_W'(TOD_N + 2);
   localparam logic [IDX_W-1:0] IX_D = IDX_W'(TOD_N + 3);

   p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      adr_we |=> idx_q == $past(wdata[IDX_W-1:0]));

   p_idx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !adr_we |=> $stable(idx_q));

   p_uip_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && idx_q == IX_A) |-> !rdata[DATA_W-1]);

   p_freeze_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(dat_we && idx_q == IX_B) |=> $stable(freeze));

   p_c_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q == IX_C) |-> rdata[DATA_W/2-1:0] == '0);

   p_d_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q == IX_D) |-> rdata == {1'b1, {(DATA_W-1){1'b0}}});

   p_tod_wr_scope_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tod_wr_en |-> (dat_we && int'(idx_q) < TOD_N));

endmodule

bind rtc_host_regs rtc_host_regs_chk #(
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W),
   .TOD_N  (TOD_N)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .adr_we    (adr_we),
   .dat_we    (dat_we),
   .wdata     (wdata),
   .rdata     (rdata),
   .freeze    (freeze),
   .tod_wr_en (tod_wr_en),
   .idx_q     (idx_q)
);

// File: tb/tb_rtc_host_regs.sv
`timescale 1ns/1ps
module tb_rtc_host_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adr_we = 1'b0, dat_we = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [79:0] tod_rd_bus;
   logic        upd_busy = 1'b0;
   logic [3:0]  irq_flags = 4'h0;
   logic        tod_wr_en, freeze;
   logic [3:0]  tod_wr_idx;
   logic [7:0]  tod_wr_data;
   logic [6:0]  ctrl_a, ctrl_b;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   // clock byte k = 0x30 + k
   for (genvar k = 0; k < 10; k++) begin : g_bus
      assign tod_rd_bus[k*8 +: 8] = 8'(8'h30 + k);
   end

   rtc_host_regs #(.RAM_CLEAR(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .adr_we(adr_we), .dat_we(dat_we),
      .wdata(wdata), .rdata(rdata), .tod_rd_bus(tod_rd_bus),
      .upd_busy(upd_busy), .irq_flags(irq_flags),
      .tod_wr_en(tod_wr_en), .tod_wr_idx(tod_wr_idx),
      .tod_wr_data(tod_wr_data), .freeze(freeze),
      .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
   );

   typedef struct packed {
      logic [1:0] op;   // 0 address, 1 data write, 2 read check
      logic [7:0] val;
      logic [7:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VT [NV] = '{
      '{2'd0, 8'h03, 8'h00, 4'd1},
      '{2'd2, 8'h00, 8'h33, 4'd2},   // R2 clock byte 3
      '{2'd0, 8'h43, 8'h00, 4'd1},
      '{2'd2, 8'h00, 8'h33, 4'd1},   // R1 wrap 0x43 -> 3
      '{2'd0, 8'h0A, 8'h00, 4'd3},
      '{2'd1, 8'h05, 8'h00, 4'd3},
      '{2'd2, 8'h00, 8'h85, 4'd3},   // R3 busy shows
      '{2'd0, 8'h0C, 8'h00, 4'd5},
      '{2'd1, 8'h55, 8'h00, 4'd5},
      '{2'd2, 8'h00, 8'hA0, 4'd5},   // R5 write ignored
      '{2'd0, 8'h0D, 8'h00, 4'd6},
      '{2'd1, 8'h00, 8'h00, 4'd6},
      '{2'd2, 8'h00, 8'h80, 4'd6},   // R6 write ignored
      '{2'd0, 8'h0E, 8'h00, 4'd7},
      '{2'd1, 8'h5A, 8'h00, 4'd7},
      '{2'd0, 8'h3F, 8'h00, 4'd7},
      '{2'd1, 8'hC3, 8'h00, 4'd7},
      '{2'd0, 8'h0E, 8'h00, 4'd7},
      '{2'd2, 8'h00, 8'h5A, 4'd7},   // R7 first byte
      '{2'd0, 8'h7F, 8'h00, 4'd1},
      '{2'd2, 8'h00, 8'hC3, 4'd7},   // R7 last byte via wrap
      '{2'd0, 8'h0B, 8'h00, 4'd4},
      '{2'd1, 8'h86, 8'h00, 4'd4},
      '{2'd2, 8'h00, 8'h86, 4'd4},   // R4 read back
      '{2'd0, 8'h0A, 8'h00, 4'd3},
      '{2'd2, 8'h00, 8'h05, 4'd3},   // R3 frozen hides busy
      '{2'd0, 8'h0B, 8'h00, 4'd4},
      '{2'd1, 8'h06, 8'h00, 4'd4},
      '{2'd2, 8'h00, 8'h06, 4'd4}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic put_addr(input logic [7:0] v);
      @(negedge clk); adr_we = 1'b1; wdata = v;
      @(negedge clk); adr_we = 1'b0;
   endtask

   task automatic put_data(input logic [7:0] v);
      @(negedge clk); dat_we = 1'b1; wdata = v;
      @(negedge clk); dat_we = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R1 reset index 0", rdata, 8'h30);
      chk("R4 reset freeze", {7'd0, freeze}, 8'h00);
      chk("R3 reset ctrl_a", {1'b0, ctrl_a}, 8'h00);
      chk("R4 reset ctrl_b", {1'b0, ctrl_b}, 8'h00);
      put_addr(8'h0A);
      chk("R3 reset A idle", rdata, 8'h00);
      upd_busy = 1'b1; #1;
      chk("R3 reset A busy", rdata, 8'h80);
      put_addr(8'h0D);
      chk("R6 reset D", rdata, 8'h80);
      put_addr(8'h0E);
      chk("R7 RAM cleared", rdata, 8'h00);
      irq_flags = 4'hA;

      // table walk
      for (int i = 0; i < NV; i++) begin
         case (VT[i].op)
            2'd0: put_addr(VT[i].val);
            2'd1: put_data(VT[i].val);
            default: chk($sformatf("R%0d row %0d", VT[i].req, i), rdata, VT[i].exp);
         endcase
      end

      // outputs of A and B
      chk("R3 ctrl_a", {1'b0, ctrl_a}, 8'h05);
      chk("R4 ctrl_b", {1'b0, ctrl_b}, 8'h06);
      chk("R4 freeze low", {7'd0, freeze}, 8'h00);
      put_data(8'h80);
      chk("R4 freeze high", {7'd0, freeze}, 8'h01);
      put_data(8'h00);
      chk("R4 freeze cleared", {7'd0, freeze}, 8'h00);

      // clock field write strobe
      put_addr(8'h05);
      chk("R8 no strobe idle", {7'd0, tod_wr_en}, 8'h00);
      @(negedge clk); dat_we = 1'b1; wdata = 8'h99; #1;
      chk("R8 strobe en", {7'd0, tod_wr_en}, 8'h01);
      chk("R8 strobe idx", {4'd0, tod_wr_idx}, 8'h05);
      chk("R8 strobe data", tod_wr_data, 8'h99);
      @(negedge clk); dat_we = 1'b0;
      chk("R2 clock byte 5 kept", rdata, 8'h35);
      put_addr(8'h0E);
      @(negedge clk); dat_we = 1'b1; wdata = 8'h44; #1;
      chk("R8 no strobe in RAM", {7'd0, tod_wr_en}, 8'h00);
      @(negedge clk); dat_we = 1'b0;

      // simultaneous strobes
      @(negedge clk); adr_we = 1'b1; dat_we = 1'b1; wdata = 8'h10;
      @(negedge clk); adr_we = 1'b0; dat_we = 1'b0;
      chk("R9 new index 16", rdata, 8'h00);
      put_addr(8'h0E);
      chk("R9 write used old index", rdata, 8'h10);

      summary();
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule